// File: doc/BRIEF.md
# Pipeline Hazard Unit

This block decides, for a five-stage in-order core, when an operand has to be bypassed from a later stage and when the front of the pipeline has to be held. It compares the source register numbers held in decode and execute with the destination register numbers and write enables of the later stages. It is purely combinational. All its outputs are plain control pins and there is no streaming interface. The core samples the outputs in the same cycle as the inputs.

Execute-stage operands may be taken from the memory stage or the writeback stage, and the newer memory-stage value wins. The decode stage compares branch operands early, so its operands may be taken from the memory stage. A load whose result is needed by the instruction right behind it holds fetch and decode and injects a bubble into execute. A branch in decode whose operand is still being produced in execute, or is still being loaded in the memory stage, triggers the same hold and bubble.

Top module: `hazard_unit`

## Requirements
- R1: `exe_fwd_a` is 2'b10 (take memory-stage result) when `exe_src_a` is nonzero, equals `mem_dst` and `mem_wr_en` is 1.
- R2: Otherwise `exe_fwd_a` is 2'b01 (take writeback result) when `exe_src_a` is nonzero, equals `wb_dst` and `wb_wr_en` is 1. In every other case it is 2'b00 (register file value). The code 2'b11 never appears.
- R3: `exe_fwd_b` follows the R1/R2 rules with `exe_src_b` in place of `exe_src_a`.
- R4: Register number 0 is never bypassed. A zero source gives 2'b00 on the execute selects and 0 on the decode selects, even when a later stage writes register 0.
- R5: A load-use hold is raised when `exe_is_load` is 1 and either `dec_src_a` or `dec_src_b` equals `exe_src_b`.
- R6: `dec_fwd_a` is 1 when `dec_src_a` is nonzero, equals `mem_dst` and `mem_wr_en` is 1. `dec_fwd_b` follows the same rule using `dec_src_b`.
- R7: A branch hold is raised when `dec_is_branch` and `exe_wr_en` are 1 and `exe_dst` equals `dec_src_a` or `dec_src_b`.
- R8: A branch hold is also raised when `dec_is_branch` and `mem_is_load` are 1 and `mem_dst` equals `dec_src_a` or `dec_src_b`.
- R9: `hold_fetch`, `hold_decode` and `flush_exe` are all equal to the OR of the load-use hold and the branch hold. With neither a load in execute nor a branch in decode, all three are 0.
- R10: When both the memory and writeback stages match an execute source, the memory-stage select (2'b10) is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_AW | First source register of the instruction in decode |
| dec_src_b | input | REG_AW | Second source register of the instruction in decode |
| exe_src_a | input | REG_AW | First source register of the instruction in execute |
| exe_src_b | input | REG_AW | Second source register in execute (a load's target) |
| exe_dst | input | REG_AW | Destination register chosen in execute |
| mem_dst | input | REG_AW | Destination register in the memory stage |
| wb_dst | input | REG_AW | Destination register in the writeback stage |
| exe_wr_en | input | 1 | Execute-stage instruction writes a register |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| exe_is_load | input | 1 | Execute-stage instruction is a load |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| dec_is_branch | input | 1 | Decode-stage instruction is a branch |
| exe_fwd_a | output | 2 | Bypass select for execute operand A |
| exe_fwd_b | output | 2 | Bypass select for execute operand B |
| dec_fwd_a | output | 1 | Bypass memory result into decode operand A |
| dec_fwd_b | output | 1 | Bypass memory result into decode operand B |
| hold_fetch | output | 1 | Keep the program counter |
| hold_decode | output | 1 | Keep the decode register |
| flush_exe | output | 1 | Clear the execute register (bubble) |

## Verification
The assertions assume the inputs have settled to known values whenever they are evaluated. They assume nothing about how the stages relate to each other. Any mix of enables and register numbers is legal, including writes to register 0 and a load flagged without a write enable. The directed stimulus drives every input from a cleared baseline each cycle and changes only the fields that a scenario needs. This keeps each expected value tied to one rule, while still covering register 0 as a destination, both stages matching at once, and the holds being absent when their qualifier is low.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_WB   = 2'b01,
    FWD_MEM  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_exe_bypass.sv
module hz_exe_bypass #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]        src,
  input  logic [AW-1:0]        mem_dst,
  input  logic [AW-1:0]        wb_dst,
  input  logic                 mem_we,
  input  logic                 wb_we,
  output hazard_pkg::fwd_sel_e sel
);
  import hazard_pkg::*;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic live, hit_mem, hit_wb;

  always_comb begin
    live    = (src != ZERO_REG);
    hit_mem = live && (src == mem_dst) && mem_we;
    hit_wb  = live && (src == wb_dst) && wb_we;
    // newer result (memory stage) wins over writeback
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
    else             sel = FWD_NONE;
  end

  always_comb begin
    if (sel == FWD_MEM)
      assert_mem_src_writes_R1: assert (mem_we && mem_dst != ZERO_REG)
        else $error("memory bypass without a live memory write");
    if (sel == FWD_WB)
      assert_wb_src_writes_R2: assert (wb_we && wb_dst != ZERO_REG)
        else $error("writeback bypass without a live writeback write");
    assert_sel_legal_R2: assert (sel != 2'b11)
      else $error("illegal bypass select");
    if (src == ZERO_REG)
      assert_zero_not_bypassed_R4: assert (sel == FWD_NONE)
        else $error("register zero bypassed in execute");
  end
endmodule

// File: rtl/hz_dec_bypass.sv
module hz_dec_bypass #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_we,
  output logic          fwd
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  always_comb fwd = (src != ZERO_REG) && (src == mem_dst) && mem_we;

  always_comb begin
    if (fwd)
      assert_dec_bypass_live_R6: assert (mem_we && mem_dst != ZERO_REG)
        else $error("decode bypass without a live memory write");
    if (src == ZERO_REG)
      assert_dec_zero_R4: assert (!fwd)
        else $error("register zero bypassed in decode");
  end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] dec_src,
  input  logic [AW-1:0]           load_dst,
  input  logic [AW-1:0]           exe_dst,
  input  logic [AW-1:0]           mem_dst,
  input  logic                    exe_we,
  input  logic                    exe_is_load,
  input  logic                    mem_is_load,
  input  logic                    dec_is_branch,
  output logic                    load_hold,
  output logic                    branch_hold
);
  logic [NSRC-1:0] use_load, use_exe, use_mem;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign use_load[g] = (dec_src[g] == load_dst);
    assign use_exe[g]  = (dec_src[g] == exe_dst);
    assign use_mem[g]  = (dec_src[g] == mem_dst);
  end

  always_comb begin
    load_hold   = exe_is_load && (|use_load);
    branch_hold = dec_is_branch &&
                  ((exe_we && (|use_exe)) || (mem_is_load && (|use_mem)));
  end

  always_comb begin
    if (!dec_is_branch)
      assert_branch_hold_needs_branch_R7: assert (!branch_hold)
        else $error("branch hold without a branch in decode");
    if (!exe_is_load)
      assert_load_hold_needs_load_R5: assert (!load_hold)
        else $error("load-use hold without a load in execute");
  end
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] dec_src_a,
  input  logic [REG_AW-1:0] dec_src_b,
  input  logic [REG_AW-1:0] exe_src_a,
  input  logic [REG_AW-1:0] exe_src_b,
  input  logic [REG_AW-1:0] exe_dst,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              exe_wr_en,
  input  logic              mem_wr_en,
  input  logic              wb_wr_en,
  input  logic              exe_is_load,
  input  logic              mem_is_load,
  input  logic              dec_is_branch,
  output logic [1:0]        exe_fwd_a,
  output logic [1:0]        exe_fwd_b,
  output logic              dec_fwd_a,
  output logic              dec_fwd_b,
  output logic              hold_fetch,
  output logic              hold_decode,
  output logic              flush_exe
);
  import hazard_pkg::*;
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] dec_src, exe_src;
  fwd_sel_e                    exe_sel [NSRC];
  logic [NSRC-1:0]             dec_sel;
  logic                        load_hold, branch_hold, stall;

  assign dec_src = {dec_src_b, dec_src_a};
  assign exe_src = {exe_src_b, exe_src_a};

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hz_exe_bypass #(.AW(REG_AW)) u_exe (
      .src(exe_src[g]), .mem_dst(mem_dst), .wb_dst(wb_dst),
      .mem_we(mem_wr_en), .wb_we(wb_wr_en), .sel(exe_sel[g])
    );
    hz_dec_bypass #(.AW(REG_AW)) u_dec (
      .src(dec_src[g]), .mem_dst(mem_dst), .mem_we(mem_wr_en),
      .fwd(dec_sel[g])
    );
  end

  hz_stall_detect #(.AW(REG_AW), .NSRC(NSRC)) u_stall (
    .dec_src(dec_src), .load_dst(exe_src_b), .exe_dst(exe_dst),
    .mem_dst(mem_dst), .exe_we(exe_wr_en), .exe_is_load(exe_is_load),
    .mem_is_load(mem_is_load), .dec_is_branch(dec_is_branch),
    .load_hold(load_hold), .branch_hold(branch_hold)
  );

  assign stall       = load_hold | branch_hold;
  assign exe_fwd_a   = exe_sel[0];
  assign exe_fwd_b   = exe_sel[1];
  assign dec_fwd_a   = dec_sel[0];
  assign dec_fwd_b   = dec_sel[1];
  assign hold_fetch  = stall;
  assign hold_decode = stall;
  assign flush_exe   = stall;

  always_comb begin
    if (!exe_is_load && !dec_is_branch)
      assert_quiet_without_cause_R9: assert (!hold_fetch && !flush_exe)
        else $error("hold raised with neither load nor branch");
    if (exe_is_load && (dec_src_a == exe_src_b || dec_src_b == exe_src_b))
      assert_load_use_holds_R5: assert (hold_decode)
        else $error("load-use dependency not held");
    if (dec_fwd_a || dec_fwd_b)
      assert_dec_bypass_needs_write_R6: assert (mem_wr_en)
        else $error("decode bypass without memory write");
    if (hold_fetch && !exe_is_load)
      assert_branch_cause_R8: assert (exe_wr_en || mem_is_load)
        else $error("branch hold with no producer in flight");
  end
endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b;
  logic [4:0] exe_dst, mem_dst, wb_dst;
  logic exe_wr_en, mem_wr_en, wb_wr_en, exe_is_load, mem_is_load, dec_is_branch;
  logic [1:0] exe_fwd_a, exe_fwd_b;
  logic dec_fwd_a, dec_fwd_b, hold_fetch, hold_decode, flush_exe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_unit #(.REG_AW(5)) i_hazard_unit (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    @(posedge clk);
    dec_src_a = 0; dec_src_b = 0; exe_src_a = 0; exe_src_b = 0;
    exe_dst = 0; mem_dst = 0; wb_dst = 0;
    exe_wr_en = 0; mem_wr_en = 0; wb_wr_en = 0;
    exe_is_load = 0; mem_is_load = 0; dec_is_branch = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic int holds();
    return {29'd0, hold_fetch, hold_decode, flush_exe};
  endfunction

  task automatic t_idle();
    clear_in(); mem_wr_en = 1; wb_wr_en = 1; settle();
    chk("R4", "idle exe_fwd_a", exe_fwd_a, 0);
    chk("R4", "idle exe_fwd_b", exe_fwd_b, 0);
    chk("R4", "idle dec_fwd", {dec_fwd_b, dec_fwd_a}, 0);
    chk("R9", "idle holds", holds(), 0);
  endtask

  task automatic t_exe_mem();
    clear_in(); exe_src_a = 5; mem_dst = 5; mem_wr_en = 1; settle();
    chk("R1", "mem bypass a", exe_fwd_a, 2);
    chk("R3", "b unaffected", exe_fwd_b, 0);
    clear_in(); exe_src_a = 5; mem_dst = 5; settle();
    chk("R1", "mem no write", exe_fwd_a, 0);
  endtask

  task automatic t_exe_wb();
    clear_in(); exe_src_a = 7; wb_dst = 7; wb_wr_en = 1; settle();
    chk("R2", "wb bypass a", exe_fwd_a, 1);
    clear_in(); exe_src_a = 7; wb_dst = 7; settle();
    chk("R2", "wb no write", exe_fwd_a, 0);
    clear_in(); exe_src_a = 7; wb_dst = 6; wb_wr_en = 1; settle();
    chk("R2", "wb mismatch", exe_fwd_a, 0);
  endtask

  task automatic t_exe_b();
    clear_in(); exe_src_b = 9; mem_dst = 9; mem_wr_en = 1; settle();
    chk("R3", "mem bypass b", exe_fwd_b, 2);
    chk("R3", "a unaffected", exe_fwd_a, 0);
    clear_in(); exe_src_b = 9; wb_dst = 9; wb_wr_en = 1; settle();
    chk("R3", "wb bypass b", exe_fwd_b, 1);
  endtask

  task automatic t_priority();
    clear_in(); exe_src_a = 3; exe_src_b = 3; mem_dst = 3; wb_dst = 3;
    mem_wr_en = 1; wb_wr_en = 1; settle();
    chk("R10", "both match a", exe_fwd_a, 2);
    chk("R10", "both match b", exe_fwd_b, 2);
    clear_in(); exe_src_a = 3; mem_dst = 3; wb_dst = 3; wb_wr_en = 1; settle();
    chk("R10", "mem disabled falls to wb", exe_fwd_a, 1);
  endtask

  task automatic t_zero();
    clear_in(); mem_wr_en = 1; wb_wr_en = 1; exe_src_b = 0; wb_dst = 0;
    mem_dst = 0; exe_src_a = 0; settle();
    chk("R4", "zero exe a", exe_fwd_a, 0);
    chk("R4", "zero exe b", exe_fwd_b, 0);
    chk("R4", "zero dec", {dec_fwd_b, dec_fwd_a}, 0);
  endtask

  task automatic t_load_use();
    clear_in(); exe_is_load = 1; exe_src_b = 4; dec_src_a = 4; settle();
    chk("R5", "load-use via a", holds(), 7);
    clear_in(); exe_is_load = 1; exe_src_b = 4; dec_src_b = 4; dec_src_a = 1; settle();
    chk("R5", "load-use via b", holds(), 7);
    clear_in(); exe_src_b = 4; dec_src_a = 4; settle();
    chk("R9", "no load no hold", holds(), 0);
    clear_in(); exe_is_load = 1; exe_src_b = 4; dec_src_a = 5; dec_src_b = 6; settle();
    chk("R5", "load no dependency", holds(), 0);
  endtask

  task automatic t_dec_fwd();
    clear_in(); dec_src_a = 6; mem_dst = 6; mem_wr_en = 1; dec_src_b = 2; settle();
    chk("R6", "dec bypass a", dec_fwd_a, 1);
    chk("R6", "dec b quiet", dec_fwd_b, 0);
    clear_in(); dec_src_b = 6; mem_dst = 6; settle();
    chk("R6", "dec no write", dec_fwd_b, 0);
    clear_in(); dec_src_b = 6; mem_dst = 6; mem_wr_en = 1; dec_src_a = 1; settle();
    chk("R6", "dec bypass b", {dec_fwd_b, dec_fwd_a}, 2);
  endtask

  task automatic t_branch_exe();
    clear_in(); dec_is_branch = 1; exe_wr_en = 1; exe_dst = 8; dec_src_b = 8;
    dec_src_a = 1; settle();
    chk("R7", "branch on exe result", holds(), 7);
    clear_in(); exe_wr_en = 1; exe_dst = 8; dec_src_b = 8; dec_src_a = 1; settle();
    chk("R9", "no branch no hold", holds(), 0);
    clear_in(); dec_is_branch = 1; exe_dst = 8; dec_src_b = 8; dec_src_a = 1; settle();
    chk("R7", "exe not writing", holds(), 0);
  endtask

  task automatic t_branch_mem();
    clear_in(); dec_is_branch = 1; mem_is_load = 1; mem_wr_en = 1; mem_dst = 2;
    dec_src_a = 2; dec_src_b = 3; settle();
    chk("R8", "branch on mem load", holds(), 7);
    clear_in(); dec_is_branch = 1; mem_wr_en = 1; mem_dst = 2;
    dec_src_a = 2; dec_src_b = 3; settle();
    chk("R8", "mem not load, no hold", holds(), 0);
    chk("R6", "mem ALU result bypassed", dec_fwd_a, 1);
  endtask

  initial begin
    clear_in();
    t_idle();
    t_exe_mem();
    t_exe_wb();
    t_exe_b();
    t_priority();
    t_zero();
    t_load_use();
    t_dec_fwd();
    t_branch_exe();
    t_branch_mem();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule